// File: doc/BRIEF.md
# Floating-Point Exception Status Update Unit

This block folds the IEEE exception flags from one completed floating-point operation into a 64-bit floating-point status word. Each request carries the five raised flags and the status word as it stands. The unit returns the updated status word, a trap request and the amount by which the program counter should move. It decides whether the operation traps by comparing the raised flags with the trap-enable field of the status word. When several enabled flags are raised at once, it keeps only the one with the highest priority. It then rewrites the current-exception field and, only when no trap occurs, adds the flags to the accrued field.

Requests enter on a valid/ready port and results leave on a valid/ready port, with one output register between them. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or its contents are being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is accepted. Producing the flags and delivering the trap are handled elsewhere.

Top module: `fpx_status_update`

## Requirements
- R1: `out_trap` is 1 exactly when at least one raised flag has its enable bit set. The enable for flag i is status bit 23+i.
- R2: On a trap, the current field (status bits 4:0) holds a single bit. That bit is the highest-priority flag among those both raised and enabled. The flag encoding, from highest to lowest priority, is bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact.
- R3: Without a trap, the current field equals the raised flags as given.
- R4: Without a trap, the accrued field (status bits 9:5) becomes its old value ORed with the current field. On a trap, the accrued field is unchanged.
- R5: On a trap, status bit 14 (IEEE fault type) is set to 1. Without a trap, it keeps its input value.
- R6: All status bits outside 4:0, 9:5 and 14 pass through unchanged.
- R7: `out_pc_inc` is 4 without a trap and 0 on a trap.
- R8: An operation with no raised flags clears the current field, leaves the accrued field unchanged and gives a PC increment of 4.
- R9: A request accepted on an edge appears on the output after that edge. A held output stays stable while `out_ready` is low, and `in_ready` is low during that time. When the output is consumed and no request is present, `out_valid` drops.
- R10: During reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_flags | input | 5 | Raised exception flags |
| in_status | input | 64 | Status word before the update |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_status | output | 64 | Updated status word |
| out_trap | output | 1 | Trap request |
| out_pc_inc | output | 4 | Program counter increment |

## Verification
Two functions can act in the same cycle. One is the trap decision, which sets the fault bit and reduces the flags to one. The other is the accrued-field update, which must not happen when a trap is taken. The sweep covers every pairing of raised flags with enable masks, so both functions are exercised in every combination. Each field is judged separately against values computed in the bench. Back-pressure is tested by presenting a second request while the first result is held. The bench then checks that the held result stays frozen, that the second request waits, and that it comes out intact once `out_ready` returns.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W    = 5;
  localparam int STATUS_W  = 64;
  localparam int EN_LSB    = 23;
  localparam int ACC_LSB   = 5;
  localparam int CUR_LSB   = 0;
  localparam int FAULT_BIT = 14;
  localparam int PC_W      = 4;
  localparam int PC_STEP   = 4;

  typedef struct packed {
    logic              trap;
    logic [FLAG_W-1:0] kept;
  } fpx_eval_t;
endpackage

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval #(
  parameter int FLAG_W = fpx_pkg::FLAG_W
) (
  input  logic [FLAG_W-1:0] raised,
  input  logic [FLAG_W-1:0] enables,
  output logic              trap,
  output logic [FLAG_W-1:0] final_flags
);
  logic [FLAG_W-1:0] masked;
  logic [FLAG_W-1:0] above;
  logic [FLAG_W-1:0] pick;

  assign masked = raised & enables;
  assign trap   = |masked;

  // Priority falls from the top bit down; a bit survives only if nothing above it is set.
  genvar i;
  generate
    for (i = 0; i < FLAG_W; i++) begin : g_prio
      if (i == FLAG_W - 1) begin : g_top
        assign above[i] = 1'b0;
      end else begin : g_rest
        assign above[i] = above[i+1] | masked[i+1];
      end
      assign pick[i] = masked[i] & ~above[i];
    end
  endgenerate

  assign final_flags = trap ? pick : raised;
endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge #(
  parameter int STATUS_W  = fpx_pkg::STATUS_W,
  parameter int FLAG_W    = fpx_pkg::FLAG_W,
  parameter int CUR_LSB   = fpx_pkg::CUR_LSB,
  parameter int ACC_LSB   = fpx_pkg::ACC_LSB,
  parameter int FAULT_BIT = fpx_pkg::FAULT_BIT
) (
  input  logic [STATUS_W-1:0] status_in,
  input  logic                trap,
  input  logic [FLAG_W-1:0]   final_flags,
  output logic [STATUS_W-1:0] status_out
);
  always_comb begin
    status_out = status_in;
    status_out[CUR_LSB +: FLAG_W] = final_flags;
    if (trap) begin
      status_out[FAULT_BIT] = 1'b1;
    end else begin
      status_out[ACC_LSB +: FLAG_W] = status_in[ACC_LSB +: FLAG_W] | final_flags;
    end
  end
endmodule

// File: rtl/fpx_status_update.sv
module fpx_status_update #(
  parameter int STATUS_W  = fpx_pkg::STATUS_W,
  parameter int FLAG_W    = fpx_pkg::FLAG_W,
  parameter int EN_LSB    = fpx_pkg::EN_LSB,
  parameter int ACC_LSB   = fpx_pkg::ACC_LSB,
  parameter int CUR_LSB   = fpx_pkg::CUR_LSB,
  parameter int FAULT_BIT = fpx_pkg::FAULT_BIT,
  parameter int PC_W      = fpx_pkg::PC_W,
  parameter int PC_STEP   = fpx_pkg::PC_STEP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [FLAG_W-1:0]   in_flags,
  input  logic [STATUS_W-1:0] in_status,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [STATUS_W-1:0] out_status,
  output logic                out_trap,
  output logic [PC_W-1:0]     out_pc_inc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  fpx_pkg::fpx_eval_t   ev;
  logic [STATUS_W-1:0]  merged;
  logic                 take;

  fpx_trap_eval #(.FLAG_W(FLAG_W)) u_eval (
    .raised      (in_flags),
    .enables     (in_status[EN_LSB +: FLAG_W]),
    .trap        (ev.trap),
    .final_flags (ev.kept)
  );

  fpx_status_merge #(
    .STATUS_W(STATUS_W), .FLAG_W(FLAG_W), .CUR_LSB(CUR_LSB),
    .ACC_LSB(ACC_LSB), .FAULT_BIT(FAULT_BIT)
  ) u_merge (
    .status_in   (in_status),
    .trap        (ev.trap),
    .final_flags (ev.kept),
    .status_out  (merged)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_status <= '0;
      out_trap   <= 1'b0;
      out_pc_inc <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_status <= merged;
        out_trap   <= ev.trap;
        out_pc_inc <= ev.trap ? '0 : STEP;
      end
    end
  end

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_status) && $stable(out_trap)));
  p_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trap) |-> out_status[FAULT_BIT]);
  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trap) |-> ($countones(out_status[CUR_LSB +: FLAG_W]) == 1));
  p_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trap) |-> (out_pc_inc == '0));
  p_accrue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ev.trap) |=> (out_status[ACC_LSB +: FLAG_W] ==
      ($past(in_status[ACC_LSB +: FLAG_W]) | $past(in_flags))));
  p_keep_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ev.trap) |=> (out_status[ACC_LSB +: FLAG_W] == $past(in_status[ACC_LSB +: FLAG_W])));
endmodule

// File: tb/fpx_status_update_bench.sv
module fpx_status_update_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_flags = '0;
  logic [63:0] in_status = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_status;
  logic        out_trap;
  logic [3:0]  out_pc_inc;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  fpx_status_update u_fpx_status_update (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flags(in_flags), .in_status(in_status), .out_valid(out_valid),
    .out_ready(out_ready), .out_status(out_status), .out_trap(out_trap),
    .out_pc_inc(out_pc_inc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_status(input logic [4:0] f, input logic [63:0] s,
                                                output logic trap);
    logic [4:0]  m;
    logic [4:0]  fin;
    logic [63:0] r;
    m    = f & s[27:23];
    trap = (m != 0);
    fin  = f;
    if (trap) begin
      fin = '0;
      for (int i = 4; i >= 0; i--) if (m[i] && fin == 0) fin[i] = 1'b1;
    end
    r = s;
    r[4:0] = fin;
    if (trap) r[14] = 1'b1;
    else r[9:5] = s[9:5] | fin;
    return r;
  endfunction

  localparam logic [63:0] OTHER = ~(64'h3FF | (64'h1 << 14));

  initial begin
    logic [63:0] s, e1, e2;
    logic t, t2;
    string ctag;
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R10 in_ready in reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    for (int k = 0; k < 1024; k++) begin
      s = 64'hA5C3_0F96_3C5A_E1D2 ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15);
      s[27:23] = k[9:5];
      @(negedge clk);
      in_valid = 1'b1; in_flags = k[4:0]; in_status = s;
      @(negedge clk);
      e1 = expect_status(k[4:0], s, t);
      ctag = (k[4:0] == 0) ? "R8 current" : (t ? "R2 current" : "R3 current");
      chk("R1 trap", {63'd0, out_trap}, {63'd0, t});
      chk(ctag, {59'd0, out_status[4:0]}, {59'd0, e1[4:0]});
      chk((k[4:0] == 0) ? "R8 accrued" : "R4 accrued", {59'd0, out_status[9:5]}, {59'd0, e1[9:5]});
      chk("R5 fault bit", {63'd0, out_status[14]}, {63'd0, e1[14]});
      chk("R6 other bits", out_status & OTHER, e1 & OTHER);
      chk("R7 pc inc", {60'd0, out_pc_inc}, t ? 64'd0 : 64'd4);
    end

    // Back-pressure: hold the first result, offer a second request.
    @(negedge clk);
    in_flags = 5'b10110; s = 64'h0123_4567_89AB_CDEF; s[27:23] = 5'b00110; in_status = s;
    e1 = expect_status(in_flags, s, t);
    @(negedge clk);
    out_ready = 1'b0;
    in_flags = 5'b00011; s = 64'hFEDC_BA98_7654_3210; s[27:23] = 5'b00000; in_status = s;
    e2 = expect_status(in_flags, s, t2);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 held status", out_status, e1);
      chk("R9 held valid", {63'd0, out_valid}, 64'd1);
      chk("R9 in_ready low", {63'd0, in_ready}, 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result", out_status, e2);
    chk("R7 second pc", {60'd0, out_pc_inc}, t2 ? 64'd0 : 64'd4);
    @(negedge clk);
    chk("R9 valid drops", {63'd0, out_valid}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule